// File: doc/BRIEF.md
# Paired Event Timestamp Monitor

This block measures the delay between a send event and a receive event. Each event line first passes through a rising-edge detector. A long level on a line therefore yields one event, on its first high cycle. Each event takes a snapshot of a free-running 16-bit cycle counter. A send event opens a pending pair. The next receive event closes that pair, and the two stamps are pushed together into a small FIFO. Software later reads the pairs and subtracts the stamps to get the delay.

The read side works as a valid/ready stream. `pair_valid` is high whenever at least one complete pair is stored, and `head_send_ts` and `head_recv_ts` show the oldest pair. Raising `pair_pop` while `pair_valid` is high removes that pair at the next clock edge. A pop while the FIFO is empty does nothing. The write side cannot be held back. When a pair completes while the FIFO is full, the pair is lost and a sticky overflow flag records the loss. The enable and clear inputs and the overflow output are plain level signals. All inputs are synchronous to `clk`, and reset is synchronous and active high.

Top module: `lat_stamp_mon`

## Requirements
- R1: After reset the timestamp counter starts at 0, advances by one on every clock, and wraps from 16'hFFFF to 16'h0000. An event takes the counter value of the cycle in which its input line first reads high.
- R2: Each event input gives exactly one event per low-to-high transition, on the first high cycle. Further high cycles, such as the second cycle of a two-cycle receive pulse, are ignored.
- R3: Events that occur while `meas_en` is low are ignored. If `meas_en` is low for any cycle, a pending send is discarded.
- R4: A send event opens a pending pair that holds its timestamp. A later send event, seen before any receive event, replaces the pending timestamp.
- R5: A receive event that finds a pending send completes the pair with its own timestamp, and `pair_valid` is high on the following cycle. A receive event with no pending send is ignored.
- R6: The FIFO holds 16 pairs and returns them oldest first. `pair_pop` while `pair_valid` is high removes the head at the next edge. `pair_pop` while `pair_valid` is low has no effect. Reset leaves the FIFO empty with overflow low.
- R7: While `pair_valid` is high and neither `pair_pop` nor `clear_req` is asserted, the head timestamps stay unchanged and `pair_valid` stays high.
- R8: A pair that completes while 16 pairs are stored is dropped and `overflow` is set. `overflow` stays set until a clear.
- R9: `clear_req` empties the FIFO, discards any pending send and clears `overflow` at the next edge. It takes priority over a push or pop in the same cycle.
- R10: When a send event and a receive event arrive in the same cycle, the receive event closes the earlier pending pair, if there is one. The send event then opens a new pair with that same timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_en | input | 1 | Enables event capture |
| send_evt | input | 1 | Send event line; the rising edge is used |
| recv_evt | input | 1 | Receive event line; the rising edge is used |
| pair_pop | input | 1 | Ready for the read stream; removes the head pair |
| clear_req | input | 1 | One-cycle strobe that empties the FIFO and clears overflow |
| pair_valid | output | 1 | At least one complete pair is stored |
| head_send_ts | output | 16 | Send timestamp of the head pair |
| head_recv_ts | output | 16 | Receive timestamp of the head pair |
| overflow | output | 1 | Sticky flag: a completed pair was dropped |

## Verification
The assertions assume that `recv_evt` is low while reset is applied. A line held high across the release of reset would count as a rising edge for the design, but not as a fresh transition for the first-cycle property. The bench holds every input low during reset. It always returns each event line low for at least one cycle before the next pulse, so every intended event is a clean edge. Pops and clears are applied as single-cycle strobes, driven half a cycle away from the capturing edge.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int unsigned LAT_TS_W  = 16;
  localparam int unsigned LAT_DEPTH = 16;
endpackage

// File: rtl/lat_edge.sv
module lat_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= 1'b0;
      else     prev[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/lat_pairer.sv
module lat_pairer #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            en,
  input  logic            snd_ev,
  input  logic            rcv_ev,
  input  logic [TS_W-1:0] stamp,
  output logic            push,
  output logic [TS_W-1:0] push_snd,
  output logic [TS_W-1:0] push_rcv
);
  logic            pend;
  logic [TS_W-1:0] pend_ts;

  always_ff @(posedge clk) begin
    if (rst || clear || !en) begin
      pend    <= 1'b0;
      pend_ts <= '0;
    end else if (snd_ev) begin
      pend    <= 1'b1;
      pend_ts <= stamp;
    end else if (rcv_ev) begin
      pend    <= 1'b0;
    end
  end

  assign push     = en && rcv_ev && pend;
  assign push_snd = pend_ts;
  assign push_rcv = stamp;
endmodule

// File: rtl/lat_fifo.sv
module lat_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic         nonempty,
  output logic [W-1:0] dout,
  output logic         ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic [AW:0]  used;
  logic         wr_ok, rd_ok;

  assign used     = wr_ptr - rd_ptr;
  assign full     = (used == (AW+1)'(DEPTH));
  assign nonempty = (used != '0);
  assign wr_ok    = push && !full;
  assign rd_ok    = pop && nonempty;
  assign dout     = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok)        wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok)        rd_ptr <= rd_ptr + 1'b1;
      if (push && full) ovf    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clear) mem[wr_ptr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/lat_stamp_mon.sv
module lat_stamp_mon
  import lat_pkg::*;
#(
  parameter int unsigned TS_W  = LAT_TS_W,
  parameter int unsigned DEPTH = LAT_DEPTH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            meas_en,
  input  logic            send_evt,
  input  logic            recv_evt,
  input  logic            pair_pop,
  input  logic            clear_req,
  output logic            pair_valid,
  output logic [TS_W-1:0] head_send_ts,
  output logic [TS_W-1:0] head_recv_ts,
  output logic            overflow
);
  localparam int unsigned PW = 2 * TS_W;

  logic [TS_W-1:0] ts_cnt;
  logic [1:0]      ev;
  logic            pair_push;
  logic [TS_W-1:0] p_snd, p_rcv;
  logic            fifo_full;
  logic [PW-1:0]   head;

  always_ff @(posedge clk) begin
    if (rst) ts_cnt <= '0;
    else     ts_cnt <= ts_cnt + 1'b1;
  end

  lat_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({recv_evt, send_evt}),
    .rise (ev)
  );

  lat_pairer #(.TS_W(TS_W)) u_pair (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_req),
    .en       (meas_en),
    .snd_ev   (ev[0]),
    .rcv_ev   (ev[1]),
    .stamp    (ts_cnt),
    .push     (pair_push),
    .push_snd (p_snd),
    .push_rcv (p_rcv)
  );

  lat_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_req),
    .push     (pair_push),
    .din      ({p_snd, p_rcv}),
    .pop      (pair_pop),
    .full     (fifo_full),
    .nonempty (pair_valid),
    .dout     (head),
    .ovf      (overflow)
  );

  assign head_send_ts = head[PW-1:TS_W];
  assign head_recv_ts = head[TS_W-1:0];
endmodule

// File: rtl/lat_stamp_mon_chk.sv
module lat_stamp_mon_chk #(
  parameter int unsigned TS_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            meas_en,
  input logic            recv_evt,
  input logic            pair_pop,
  input logic            clear_req,
  input logic            pair_valid,
  input logic [TS_W-1:0] head_send_ts,
  input logic [TS_W-1:0] head_recv_ts,
  input logic            overflow,
  input logic            push,
  input logic            full
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_first_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    push && seen |-> !$past(recv_evt));

  p_gated_r3: assert property (@(posedge clk) disable iff (rst)
    push |-> meas_en);

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    !pair_valid && !push |=> !pair_valid);

  p_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
    pair_valid && !pair_pop && !clear_req |=>
      pair_valid && $stable(head_send_ts) && $stable(head_recv_ts));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow && !clear_req |=> overflow);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(full && push));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> !pair_valid && !overflow);
endmodule

bind lat_stamp_mon lat_stamp_mon_chk #(.TS_W(TS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .meas_en      (meas_en),
  .recv_evt     (recv_evt),
  .pair_pop     (pair_pop),
  .clear_req    (clear_req),
  .pair_valid   (pair_valid),
  .head_send_ts (head_send_ts),
  .head_recv_ts (head_recv_ts),
  .overflow     (overflow),
  .push         (pair_push),
  .full         (fifo_full)
);

// File: tb/sim_lat_stamp_mon.sv
`timescale 1ns/1ps
module sim_lat_stamp_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic meas_en = 1'b0, send_evt = 1'b0, recv_evt = 1'b0;
  logic pair_pop = 1'b0, clear_req = 1'b0;
  logic pair_valid, overflow;
  logic [15:0] head_send_ts, head_recv_ts;
  logic [15:0] tb_cnt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 1'b1;
  end

  lat_stamp_mon u0 (
    .clk(clk), .rst(rst), .meas_en(meas_en), .send_evt(send_evt),
    .recv_evt(recv_evt), .pair_pop(pair_pop), .clear_req(clear_req),
    .pair_valid(pair_valid), .head_send_ts(head_send_ts),
    .head_recv_ts(head_recv_ts), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit s, input bit r, input int len, output logic [15:0] ts);
    send_evt = s;
    recv_evt = r;
    ts = tb_cnt;
    repeat (len) @(negedge clk);
    send_evt = 1'b0;
    recv_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_pop();
    pair_pop = 1'b1;
    @(negedge clk);
    pair_pop = 1'b0;
  endtask

  task automatic do_clear();
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6 reset valid", pair_valid, 0);
    chk("R6 reset overflow", overflow, 0);
  endtask

  task automatic t_basic();
    logic [15:0] s, r;
    meas_en = 1'b1;
    drive(1, 0, 1, s);
    idle(2);
    drive(0, 1, 2, r);
    chk("R5 pair ready", pair_valid, 1);
    chk("R4 send stamp", head_send_ts, s);
    chk("R1 recv stamp", head_recv_ts, r);
    do_pop();
    chk("R2 wide recv gives one pair", pair_valid, 0);
  endtask

  task automatic t_long_send();
    logic [15:0] s, r;
    drive(1, 0, 4, s);
    drive(0, 1, 1, r);
    chk("R2 first cycle of long send", head_send_ts, s);
    chk("R2 recv stamp", head_recv_ts, r);
    do_pop();
    chk("R2 single pair", pair_valid, 0);
  endtask

  task automatic t_orphan();
    logic [15:0] r;
    drive(0, 1, 1, r);
    idle(2);
    chk("R5 orphan recv ignored", pair_valid, 0);
  endtask

  task automatic t_replace();
    logic [15:0] s1, s2, r;
    drive(1, 0, 1, s1);
    drive(1, 0, 1, s2);
    drive(0, 1, 1, r);
    chk("R4 newer send replaces", head_send_ts, s2);
    chk("R4 recv stamp", head_recv_ts, r);
    do_pop();
    chk("R4 only one pair", pair_valid, 0);
  endtask

  task automatic t_disabled();
    logic [15:0] s, r;
    meas_en = 1'b0;
    drive(1, 0, 1, s);
    drive(0, 1, 1, r);
    chk("R3 disabled events ignored", pair_valid, 0);
    meas_en = 1'b1;
    drive(1, 0, 1, s);
    meas_en = 1'b0;
    @(negedge clk);
    meas_en = 1'b1;
    drive(0, 1, 1, r);
    chk("R3 pending dropped by disable", pair_valid, 0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] s, t, r;
    drive(1, 0, 1, s);
    drive(1, 1, 1, t);
    drive(0, 1, 1, r);
    chk("R10 first pair send", head_send_ts, s);
    chk("R10 first pair recv", head_recv_ts, t);
    do_pop();
    chk("R10 second pair send", head_send_ts, t);
    chk("R10 second pair recv", head_recv_ts, r);
    do_pop();
    chk("R10 drained", pair_valid, 0);
  endtask

  task automatic t_fill_overflow();
    logic [15:0] es [17];
    logic [15:0] er [17];
    logic [15:0] hs, hr;
    for (int i = 0; i < 17; i++) begin
      drive(1, 0, 1, es[i]);
      drive(0, 1, 1, er[i]);
    end
    chk("R8 overflow set", overflow, 1);
    hs = head_send_ts;
    hr = head_recv_ts;
    idle(5);
    chk("R7 head send held", head_send_ts, hs);
    chk("R7 head recv held", head_recv_ts, hr);
    for (int i = 0; i < 16; i++) begin
      chk("R6 order send", head_send_ts, es[i]);
      chk("R6 order recv", head_recv_ts, er[i]);
      do_pop();
    end
    chk("R8 17th pair dropped", pair_valid, 0);
    chk("R8 overflow sticky", overflow, 1);
  endtask

  task automatic t_pop_empty();
    logic [15:0] s, r;
    do_pop();
    do_pop();
    drive(1, 0, 1, s);
    drive(0, 1, 1, r);
    chk("R6 pop on empty harmless send", head_send_ts, s);
    chk("R6 pop on empty harmless recv", head_recv_ts, r);
  endtask

  task automatic t_clear();
    logic [15:0] s, r;
    drive(1, 0, 1, s);
    drive(0, 1, 1, r);
    chk("R9 pairs before clear", pair_valid, 1);
    do_clear();
    chk("R9 clear empties", pair_valid, 0);
    chk("R9 clear drops overflow", overflow, 0);
    drive(1, 0, 1, s);
    do_clear();
    drive(0, 1, 1, r);
    chk("R9 clear drops pending", pair_valid, 0);
  endtask

  task automatic t_wrap();
    logic [15:0] s, r;
    while (tb_cnt != 16'hFFFD) @(negedge clk);
    drive(1, 0, 1, s);
    idle(2);
    drive(0, 1, 1, r);
    chk("R1 stamp before wrap", head_send_ts, 16'hFFFD);
    chk("R1 stamp after wrap", head_recv_ts, 16'h0001);
    do_pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_long_send();
    t_orphan();
    t_replace();
    t_disabled();
    t_same_cycle();
    t_fill_overflow();
    t_pop_empty();
    t_clear();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule